// File: doc/BRIEF.md
# Half-Bridge Driver Control and Fault Register File

This block is the byte-wide register bank that sits between a serial frame decoder and the control logic of a half-bridge driver. The decoder presents single-byte register reads and writes on a request channel. The bank answers reads on a response channel one cycle later. Inside, the bank holds four groups of state:

- sticky fault flags, set by single-cycle event pulses from the protection logic;
- a command register with two lock keys and a clear-fault strobe;
- a lockable register that carries software copies of the bridge input and disable controls;
- four configuration registers that can be locked.

The bank drives an active-low fault output. It also merges the physical input and disable pins with their register copies, using OR or AND as selected in the configuration. The request channel uses valid/ready. The bank never applies back-pressure: `req_ready` is held at 1, so a request is accepted in every cycle where `req_valid` is 1. The response channel has no ready signal. `rsp_valid` is 1 for exactly one cycle, the cycle after an accepted read, and the consumer must take the data in that cycle.

Top module: `hb_ctrl_regbank`

## Requirements
- R1: After reset the bank reads as follows, and `fault_n` is 0 because the power-on flag is set:

  | Address | Value |
  |---|---|
  | 00h | 2Ch |
  | 01h | 60h |
  | 08h | 09h |
  | 09h | 0Ch |
  | 0Ah | 10h |
  | 0Bh | 18h |
  | 0Ch | 62h |
  | 0Dh | 44h |

- R2: Reads of any address other than 00h–03h and 08h–0Dh return 00h, and writes to them are ignored. Writes to the read-only addresses 00h–03h are also ignored. Neither kind of write sets the error flag.
- R3: Address 01h reads {ERR, POR, FAULT, VMOV, VMUV, OCP, TSD, OLA}, bit 7 first. An event pulse sets its flag, and the flag stays set until a clear. If an event arrives in the same cycle as a clear, the event wins and its flag stays set.
- R4: FAULT (bit 5 of 01h) is the OR of ERR, POR, VMUV, OCP and TSD. `fault_n` is 0 in two cases: when FAULT is 1, or when the over-temperature-warning flag is set and bit 7 of 0Dh is 1. VMOV and OLA on their own leave `fault_n` at 1.
- R5: Writing a byte with bit 7 set to 08h clears every sticky flag, including POR and the warning flag, and sets `fault_n` to 1. Bit 7 of 08h always reads 0.
- R6: Bits 4:3 of 08h hold the input-register key.
  - Code 10b unlocks 09h. Any other code locks it. While 09h is locked, writes to it are ignored.
  - 09h reads {0000b, DRVOFF copy, 10b, IN copy}.
- R7: Bits 1:0 of 08h hold the configuration key.
  - Code 10b locks 0Ah–0Dh, so writes to them are ignored. Any other code unlocks them.
  - 08h reads {000b, input key, 0b, configuration key}.
- R8: How the effective outputs are formed depends on whether 09h is unlocked.
  - While 09h is unlocked, `eff_in` is `pin_in` combined with bit 0 of 09h, and `eff_drvoff` is `pin_drvoff` combined with bit 3 of 09h.
  - The IN combination uses bit 0 of 0Dh and the DRVOFF combination uses bit 2 of 0Dh. In each case the select bit gives OR when 0 and AND when 1.
  - While 09h is locked, each effective output equals its pin.
- R9: Address 02h reads {00b, `itrip_i`, `active_i`, 0000b}. Address 03h reads {`pin_drvoff`, 0b, warning flag, `active_i`, 000b, `olp_cmp_i`}.
- R10: Some configuration bits read as constants.
  - Bit 7 of 0Bh reads 0.
  - In 0Ch, bit 5 reads 1 and bits 1:0 read 10b, whatever was written.
  - All other configuration bits read back what was written.
- R11: `req_ready` is always 1. `rsp_valid` is 1 exactly in the cycle after an accepted read and carries that read's data. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| evt_err | input | 1 | Frame error pulse |
| evt_vmov | input | 1 | Supply overvoltage pulse |
| evt_vmuv | input | 1 | Supply undervoltage pulse |
| evt_ocp | input | 1 | Overcurrent pulse |
| evt_tsd | input | 1 | Thermal shutdown pulse |
| evt_ola | input | 1 | Active open-load pulse |
| evt_otw | input | 1 | Over-temperature warning pulse |
| active_i | input | 1 | Live bridge-active status |
| itrip_i | input | 1 | Live current-regulation comparator |
| olp_cmp_i | input | 1 | Live off-state comparator |
| pin_in | input | 1 | Physical bridge input pin |
| pin_drvoff | input | 1 | Physical bridge disable pin |
| eff_in | output | 1 | Merged bridge input |
| eff_drvoff | output | 1 | Merged bridge disable |
| fault_n | output | 1 | Active-low fault output |
| cfg_word | output | 32 | Stored values of 0Dh, 0Ch, 0Bh, 0Ah from high byte to low byte |

## Verification
The assertions check these properties on every cycle:

- each sticky flag holds across any cycle without a clear;
- an event always leaves its flag set, even when a clear arrives in the same cycle;
- a clear with no event pending releases `fault_n`;
- writes under a lock never change 09h or the configuration bytes;
- while 09h is locked, the effective outputs follow their pins;
- the response strobe follows accepted reads exactly.

Only the bench scenarios can show the rest:

- the exact read encodings and reset values;
- which flags feed FAULT and `fault_n`;
- the OR and AND merge results for each select setting;
- the constant bits in the configuration bytes.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NCFG = 4;
  localparam int NFLG = 8;
  localparam int NPIN = 2;

  localparam logic [AW-1:0] ADR_ID   = 8'h00;
  localparam logic [AW-1:0] ADR_FLT  = 8'h01;
  localparam logic [AW-1:0] ADR_ST1  = 8'h02;
  localparam logic [AW-1:0] ADR_ST2  = 8'h03;
  localparam logic [AW-1:0] ADR_CMD  = 8'h08;
  localparam logic [AW-1:0] ADR_INC  = 8'h09;
  localparam logic [AW-1:0] ADR_CFG0 = 8'h0A;

  localparam logic [DW-1:0] ID_WORD  = 8'h2C;
  localparam logic [1:0]    KEY_CODE = 2'b10;
  localparam logic [1:0]    KEY_RST  = 2'b01;

  // sticky flag positions inside the flag vector
  localparam int FL_OLA  = 0;
  localparam int FL_TSD  = 1;
  localparam int FL_OCP  = 2;
  localparam int FL_VMUV = 3;
  localparam int FL_VMOV = 4;
  localparam int FL_ERR  = 5;
  localparam int FL_POR  = 6;
  localparam int FL_OTW  = 7;
  localparam logic [NFLG-1:0] FLG_RST = NFLG'(1) << FL_POR;

  function automatic logic [DW-1:0] cfg_reset(input int i);
    case (i)
      0:       return 8'h10;
      1:       return 8'h18;
      2:       return 8'h40;
      default: return 8'h44;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_wmask(input int i);
    case (i)
      1:       return 8'h7F;
      2:       return 8'hDC;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_fixed(input int i);
    return (i == 2) ? 8'h22 : 8'h00;
  endfunction
endpackage

// File: rtl/hbr_fault_bank.sv
module hbr_fault_bank #(
  parameter int N = 8,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_q
);
  // a set in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= RST_VAL;
    else        flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end
endmodule

// File: rtl/hbr_cfg_bank.sv
module hbr_cfg_bank import hbr_pkg::*; #(
  parameter int N = NCFG,
  parameter int W = DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [N-1:0]        wr_sel_i,
  input  logic [W-1:0]        wdata_i,
  output logic [N-1:0][W-1:0] cfg_q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [W-1:0] MASK = W'(cfg_wmask(g));
    localparam logic [W-1:0] RSTV = W'(cfg_reset(g)) & MASK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cfg_q[g] <= RSTV;
      else if (wr_en_i && wr_sel_i[g]) cfg_q[g] <= wdata_i & MASK;
    end
  end
endmodule

// File: rtl/hbr_pin_merge.sv
module hbr_pin_merge #(
  parameter int N = 2
) (
  input  logic         open_i,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] reg_i,
  input  logic [N-1:0] and_sel_i,
  output logic [N-1:0] eff_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic comb;
    assign comb     = and_sel_i[g] ? (pin_i[g] & reg_i[g]) : (pin_i[g] | reg_i[g]);
    assign eff_o[g] = open_i ? comb : pin_i[g];
  end
endmodule

// File: rtl/hb_ctrl_regbank.sv
module hb_ctrl_regbank import hbr_pkg::*; #(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW,
  parameter int N_CFG  = NCFG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic                    evt_err,
  input  logic                    evt_vmov,
  input  logic                    evt_vmuv,
  input  logic                    evt_ocp,
  input  logic                    evt_tsd,
  input  logic                    evt_ola,
  input  logic                    evt_otw,
  input  logic                    active_i,
  input  logic                    itrip_i,
  input  logic                    olp_cmp_i,
  input  logic                    pin_in,
  input  logic                    pin_drvoff,
  output logic                    eff_in,
  output logic                    eff_drvoff,
  output logic                    fault_n,
  output logic [N_CFG*DATA_W-1:0] cfg_word
);
  localparam int INC_DRV = 1;
  localparam int INC_IN  = 0;

  logic rd_acc, wr_acc, hit_cmd, hit_inc, clr;
  logic [N_CFG-1:0] hit_cfg;
  logic [1:0] spi_key, cfg_key;
  logic spi_open, cfg_open;
  logic [1:0] inc_q;
  logic [NFLG-1:0] set_v, flags;
  logic summ;
  logic [N_CFG-1:0][DATA_W-1:0] cfg;
  logic [DATA_W-1:0] rd_word;

  assign req_ready = 1'b1;
  assign rd_acc    = req_valid & ~req_write;
  assign wr_acc    = req_valid & req_write;
  assign hit_cmd   = wr_acc && (req_addr == ADDR_W'(ADR_CMD));
  assign hit_inc   = wr_acc && (req_addr == ADDR_W'(ADR_INC));

  for (genvar g = 0; g < N_CFG; g++) begin : g_hit
    assign hit_cfg[g] = wr_acc && (req_addr == ADDR_W'(ADR_CFG0) + ADDR_W'(g));
  end

  // command register: two keys plus a self-clearing strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_key <= KEY_RST;
      cfg_key <= KEY_RST;
    end else if (hit_cmd) begin
      spi_key <= req_wdata[4:3];
      cfg_key <= req_wdata[1:0];
    end
  end
  assign spi_open = (spi_key == KEY_CODE);
  assign cfg_open = (cfg_key != KEY_CODE);
  assign clr      = hit_cmd & req_wdata[7];

  // input-control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= 2'b10;
    end else if (hit_inc && spi_open) begin
      inc_q[INC_DRV] <= req_wdata[3];
      inc_q[INC_IN]  <= req_wdata[0];
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[FL_OLA]  = evt_ola;
    set_v[FL_TSD]  = evt_tsd;
    set_v[FL_OCP]  = evt_ocp;
    set_v[FL_VMUV] = evt_vmuv;
    set_v[FL_VMOV] = evt_vmov;
    set_v[FL_ERR]  = evt_err;
    set_v[FL_OTW]  = evt_otw;
  end

  hbr_fault_bank #(.N(NFLG), .RST_VAL(FLG_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr), .flags_q(flags)
  );

  assign summ = flags[FL_ERR] | flags[FL_POR] | flags[FL_VMUV] | flags[FL_OCP] | flags[FL_TSD];
  assign fault_n = ~(summ | (flags[FL_OTW] & cfg[N_CFG-1][7]));

  hbr_cfg_bank #(.N(N_CFG), .W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_open), .wr_sel_i(hit_cfg),
    .wdata_i(req_wdata), .cfg_q(cfg)
  );
  assign cfg_word = cfg;

  hbr_pin_merge #(.N(NPIN)) u_merge (
    .open_i(spi_open),
    .pin_i({pin_drvoff, pin_in}),
    .reg_i({inc_q[INC_DRV], inc_q[INC_IN]}),
    .and_sel_i({cfg[N_CFG-1][2], cfg[N_CFG-1][0]}),
    .eff_o({eff_drvoff, eff_in})
  );

  always_comb begin
    rd_word = '0;
    case (req_addr)
      ADDR_W'(ADR_ID):  rd_word = DATA_W'(ID_WORD);
      ADDR_W'(ADR_FLT): rd_word = {flags[FL_ERR], flags[FL_POR], summ, flags[FL_VMOV],
                                   flags[FL_VMUV], flags[FL_OCP], flags[FL_TSD], flags[FL_OLA]};
      ADDR_W'(ADR_ST1): rd_word = {2'b00, itrip_i, active_i, 4'b0000};
      ADDR_W'(ADR_ST2): rd_word = {pin_drvoff, 1'b0, flags[FL_OTW], active_i, 3'b000, olp_cmp_i};
      ADDR_W'(ADR_CMD): rd_word = {3'b000, spi_key, 1'b0, cfg_key};
      ADDR_W'(ADR_INC): rd_word = {4'b0000, inc_q[INC_DRV], 2'b10, inc_q[INC_IN]};
      default: begin
        for (int g = 0; g < N_CFG; g++) begin
          if (req_addr == ADDR_W'(ADR_CFG0) + ADDR_W'(g))
            rd_word = cfg[g] | DATA_W'(cfg_fixed(g));
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/hbr_regbank_chk.sv
module hbr_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic        rsp_valid,
  input logic        fault_n,
  input logic        pin_in,
  input logic        pin_drvoff,
  input logic        eff_in,
  input logic        eff_drvoff,
  input logic [7:0]  flags,
  input logic [7:0]  set_v,
  input logic        clr,
  input logic        spi_open,
  input logic        cfg_open,
  input logic [1:0]  inc_q,
  input logic [31:0] cfg_word
);
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((flags & $past(set_v)) == $past(set_v)));

  p_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set_v == 8'h00)) |=> fault_n);

  p_inc_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_open && req_valid && req_write && req_addr == 8'h09) |=> $stable(inc_q));

  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && req_valid && req_write && req_addr >= 8'h0A && req_addr <= 8'h0D)
      |=> $stable(cfg_word));

  p_pins_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_open |-> (eff_in == pin_in && eff_drvoff == pin_drvoff));

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind hb_ctrl_regbank hbr_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .fault_n(fault_n),
  .pin_in(pin_in), .pin_drvoff(pin_drvoff), .eff_in(eff_in), .eff_drvoff(eff_drvoff),
  .flags(flags), .set_v(set_v), .clr(clr), .spi_open(spi_open), .cfg_open(cfg_open),
  .inc_q(inc_q), .cfg_word(cfg_word)
);

// File: tb/hb_ctrl_regbank_test.sv
`timescale 1ns/1ps
module hb_ctrl_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic evt_err = 0, evt_vmov = 0, evt_vmuv = 0, evt_ocp = 0, evt_tsd = 0, evt_ola = 0, evt_otw = 0;
  logic active_i = 0, itrip_i = 0, olp_cmp_i = 0, pin_in = 0, pin_drvoff = 0;
  logic eff_in, eff_drvoff, fault_n;
  logic [31:0] cfg_word;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  hb_ctrl_regbank uut (.*);

  typedef struct packed {
    logic       wr;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [3:0] rq;
  } vec_t;

  // wr=1: write dat; wr=0: read and expect dat
  localparam vec_t VEC [32] = '{
    '{1'b0, 8'h00, 8'h2C, 4'd1},  // R1
    '{1'b0, 8'h01, 8'h60, 4'd1},  // R1
    '{1'b0, 8'h08, 8'h09, 4'd1},  // R1
    '{1'b0, 8'h09, 8'h0C, 4'd1},  // R1
    '{1'b0, 8'h0A, 8'h10, 4'd1},  // R1
    '{1'b0, 8'h0B, 8'h18, 4'd1},  // R1
    '{1'b0, 8'h0C, 8'h62, 4'd1},  // R1
    '{1'b0, 8'h0D, 8'h44, 4'd1},  // R1
    '{1'b0, 8'h05, 8'h00, 4'd2},  // R2 reserved read
    '{1'b1, 8'h05, 8'hFF, 4'd2},  // R2 reserved write
    '{1'b0, 8'h05, 8'h00, 4'd2},  // R2
    '{1'b1, 8'h00, 8'hFF, 4'd2},  // R2 read-only write
    '{1'b0, 8'h00, 8'h2C, 4'd2},  // R2
    '{1'b1, 8'h0B, 8'hFF, 4'd10}, // R10
    '{1'b0, 8'h0B, 8'h7F, 4'd10}, // R10
    '{1'b1, 8'h0C, 8'hFF, 4'd10}, // R10
    '{1'b0, 8'h0C, 8'hFE, 4'd10}, // R10
    '{1'b1, 8'h0C, 8'h00, 4'd10}, // R10
    '{1'b0, 8'h0C, 8'h22, 4'd10}, // R10
    '{1'b1, 8'h09, 8'hFF, 4'd6},  // R6 locked write
    '{1'b0, 8'h09, 8'h0C, 4'd6},  // R6
    '{1'b1, 8'h08, 8'h12, 4'd6},  // R6 unlock input, lock config
    '{1'b0, 8'h08, 8'h12, 4'd6},  // R6
    '{1'b1, 8'h0A, 8'h55, 4'd7},  // R7 locked write
    '{1'b0, 8'h0A, 8'h10, 4'd7},  // R7
    '{1'b1, 8'h09, 8'h01, 4'd6},  // R6 unlocked write
    '{1'b0, 8'h09, 8'h05, 4'd6},  // R6
    '{1'b1, 8'h08, 8'h08, 4'd7},  // R7 unlock config, lock input
    '{1'b0, 8'h08, 8'h08, 4'd7},  // R7
    '{1'b1, 8'h0A, 8'h55, 4'd7},  // R7
    '{1'b0, 8'h0A, 8'h55, 4'd7},  // R7
    '{1'b0, 8'h01, 8'h60, 4'd2}   // R2 no error flag raised
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check({tag, " rsp_valid"}, {7'd0, rsp_valid}, 8'h01);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 ready", {7'd0, req_ready}, 8'h01);
    check("R11 idle rsp", {7'd0, rsp_valid}, 8'h00);
    check("R1 fault_n reset", {7'd0, fault_n}, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i].wr) wr(VEC[i].adr, VEC[i].dat);
      else rd(VEC[i].adr, VEC[i].dat, $sformatf("R%0d vec%0d", VEC[i].rq, i));
    end

    // R5 clear releases everything, bit 7 reads back 0
    wr(8'h08, 8'h89);
    rd(8'h01, 8'h00, "R5 clear");
    check("R5 fault_n", {7'd0, fault_n}, 8'h01);
    rd(8'h08, 8'h09, "R5 strobe reads 0");

    // R3 sticky overcurrent, R4 summary and output
    @(negedge clk); evt_ocp = 1; @(negedge clk); evt_ocp = 0;
    repeat (2) @(negedge clk);
    rd(8'h01, 8'h24, "R3 ocp sticky");
    check("R4 fault_n ocp", {7'd0, fault_n}, 8'h00);

    // R4 VMOV and OLA stay out of the summary
    wr(8'h08, 8'h89);
    @(negedge clk); evt_vmov = 1; evt_ola = 1; @(negedge clk); evt_vmov = 0; evt_ola = 0;
    rd(8'h01, 8'h11, "R4 vmov ola");
    check("R4 fault_n vmov", {7'd0, fault_n}, 8'h01);

    // R3 event in the clearing cycle wins
    @(negedge clk);
    evt_tsd = 1; req_valid = 1; req_write = 1; req_addr = 8'h08; req_wdata = 8'h89;
    @(negedge clk);
    evt_tsd = 0; req_valid = 0; req_write = 0;
    rd(8'h01, 8'h22, "R3 event beats clear");

    wr(8'h08, 8'h89);
    @(negedge clk); evt_err = 1; @(negedge clk); evt_err = 0;
    rd(8'h01, 8'hA0, "R3 err flag");

    // R9 status words, R4 warning reporting
    wr(8'h08, 8'h89);
    pin_drvoff = 1; active_i = 1; olp_cmp_i = 1; itrip_i = 1;
    @(negedge clk); evt_otw = 1; @(negedge clk); evt_otw = 0;
    rd(8'h03, 8'hB1, "R9 status2");
    check("R4 otw unreported", {7'd0, fault_n}, 8'h01);
    wr(8'h0D, 8'hC4);
    check("R4 otw reported", {7'd0, fault_n}, 8'h00);
    rd(8'h02, 8'h30, "R9 status1");
    wr(8'h08, 8'h89);
    check("R5 otw cleared fault_n", {7'd0, fault_n}, 8'h01);
    rd(8'h03, 8'h91, "R5 otw cleared");
    wr(8'h0D, 8'h44);

    // R8 pin merge (09h holds IN copy 1, DRVOFF copy 0)
    pin_in = 0; pin_drvoff = 1;
    @(negedge clk);
    check("R8 locked in", {7'd0, eff_in}, 8'h00);
    check("R8 locked drvoff", {7'd0, eff_drvoff}, 8'h01);
    wr(8'h08, 8'h11);
    check("R8 in OR", {7'd0, eff_in}, 8'h01);
    check("R8 drvoff AND", {7'd0, eff_drvoff}, 8'h00);
    wr(8'h0D, 8'h41);
    check("R8 in AND low", {7'd0, eff_in}, 8'h00);
    pin_in = 1; @(negedge clk);
    check("R8 in AND high", {7'd0, eff_in}, 8'h01);
    check("R8 drvoff OR pin", {7'd0, eff_drvoff}, 8'h01);
    pin_drvoff = 0; @(negedge clk);
    check("R8 drvoff OR low", {7'd0, eff_drvoff}, 8'h00);
    wr(8'h09, 8'h08);
    check("R8 drvoff OR reg", {7'd0, eff_drvoff}, 8'h01);
    check("R8 in AND reg0", {7'd0, eff_in}, 8'h00);
    wr(8'h08, 8'h09);
    check("R8 relock drvoff", {7'd0, eff_drvoff}, 8'h00);
    check("R8 relock in", {7'd0, eff_in}, 8'h01);
    check("R11 idle rsp end", {7'd0, rsp_valid}, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule